// File: doc/BRIEF.md
# Timekeeping Counters with Alarms

This block keeps three binary counters for a timekeeping subsystem. A real-time counter and an interval timer, each 40 bits wide, advance once per 1/256-second tick, so the low byte holds fractions of a second and the upper bytes hold whole seconds. A 32-bit cycle counter counts qualified high-to-low changes of a monitored external line. Each counter has its own alarm compare register. When a counter advances onto its alarm value it raises a flag, and that flag can drive an interrupt.

A qualifier filters the monitored line using a millisecond tick input. A level is only accepted after the line has held it for one of two delays, chosen by a control bit. The accepted level gates the interval timer in auto mode and supplies the edges for the cycle counter. A host reaches the block through a byte-addressed register port. A snapshot strobe copies every counter into holding registers, so a multi-byte value can be read without changing partway through the read. Per-counter write-protect bits lock a counter and its alarm until the block is reset.

Top module: `tk_core`

## Requirements
- R1: After reset all counters and alarms are 0, the status register (address 0) reads 0x38, the control register (address 1) reads 0x00 and irq_o is low.
- R2: While control bit 4 (oscillator) is 1, the real-time counter (bytes at addresses 2..6, least significant byte first) advances by one on each tick_i pulse, and carries propagate across bytes.
- R3: While control bit 4 is 0, no counter advances on tick_i or on line activity.
- R4: With control bit 5 at 0 (manual), the interval timer (addresses 7..11, LSB first) counts ticks while control bit 6 is 0 and holds while bit 6 is 1.
- R5: Alarm registers sit at addresses 16..20 (real-time), 21..25 (interval) and 26..29 (cycle), LSB first. A status flag (bit 0 real-time, bit 1 interval, bit 2 cycle) sets when its counter advances onto a value equal to its alarm.
- R6: irq_o goes high one cycle after a flag is set whose enable bit (status bit 3, 4 or 5, same order) is 0. A flag whose enable bit is 1 leaves irq_o low.
- R7: A status read returns the flags as they were before the read and then clears them. A status write changes only bits 3..5.
- R8: Counter reads return the holding copy taken at the most recent snap_i pulse. rdata_o is valid the cycle after rd_en_i.
- R9: Control bits 0..2 (write protect for real-time, interval and cycle) can be set by a write but not cleared. While one of these bits is set, writes to that counter and to its alarm are ignored.
- R10: The qualified line level changes only after line_i has held the opposite level for LONG_MS ms ticks (control bit 7 = 1) or SHORT_MS ms ticks (bit 7 = 0). Any return to the current level during the wait restarts the count.
- R11: With control bit 5 at 1 (auto), the interval timer counts ticks only while the qualified level is high.
- R12: The cycle counter (addresses 12..15, LSB first) increases by one on each qualified high-to-low change of the line.
- R13: Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse at 256 Hz |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond, used by the line qualifier |
| line_i | input | 1 | Monitored external line |
| snap_i | input | 1 | Copies all counters into holding registers |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Active-high interrupt, OR of all unmasked flags |

## Verification
A counter stuck or skipping inside the block only shows at the ports after a snapshot and a byte read. For that reason each counting check takes a fresh snapshot and compares the byte values against a count of the ticks and filtered edges the bench applied. A flag set at the wrong time appears on irq_o within two cycles of the offending tick. A wrong qualifier count shows up as an interval timer that starts or stops one tick-window too early or too late, or as a cycle count that is off by one. The restart case and the long-delay case are placed exactly one millisecond tick short of the threshold, so an off-by-one in the qualifier is visible.

// File: rtl/tk_pkg.sv
package tk_pkg;
  // control register bit positions
  localparam int CB_OSC  = 4;
  localparam int CB_AUTO = 5;
  localparam int CB_STOP = 6;
  localparam int CB_DSEL = 7;
  // number of alarm sources and their flag order
  localparam int NSRC = 3;
  typedef enum int {SRC_RTC = 0, SRC_IVT = 1, SRC_CYC = 2} src_e;

  function automatic logic in_window(int a, int base, int len);
    return (a >= base) && (a < base + len);
  endfunction
endpackage

// File: rtl/tk_line_qual.sv
module tk_line_qual #(
  parameter int LONG_MS  = 123,
  parameter int SHORT_MS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic ms_tick_i,
  input  logic long_sel_i,
  output logic level_o,
  output logic fall_o
);
  localparam int MAXD = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
  localparam int CW   = $clog2(MAXD + 1);

  logic          line_q;
  logic          level_q;
  logic          fall_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = long_sel_i ? CW'(LONG_MS - 1) : CW'(SHORT_MS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= 1'b0;
      level_q <= 1'b0;
      fall_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      line_q <= line_i;
      fall_q <= 1'b0;
      if (line_q == level_q) begin
        cnt_q <= '0;                 // wait restarts on any return
      end else if (ms_tick_i) begin
        if (cnt_q >= limit) begin
          level_q <= line_q;
          fall_q  <= level_q;        // accepted 1 -> 0 change
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign level_o = level_q;
  assign fall_o  = fall_q;
endmodule

// File: rtl/tk_count_alarm.sv
module tk_count_alarm #(
  parameter int BYTES  = 5,
  parameter int ADDR_W = 6,
  parameter int CBASE  = 2,
  parameter int ABASE  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_i,
  input  logic              snap_i,
  input  logic              lock_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [8*BYTES-1:0] hold_o,
  output logic [7:0]        rd_o,
  output logic              hit_o
);
  import tk_pkg::*;
  localparam int W  = 8 * BYTES;
  localparam int SW = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [W-1:0]  cnt_q, alm_q, hold_q;
  logic [W-1:0]  cnt_n, alm_n, cnt_inc;
  logic          hit_q;
  logic          in_cnt, in_alm, cnt_we, alm_we, step;
  logic [SW-1:0] cnt_sel, alm_sel;

  assign in_cnt  = in_window(int'(addr_i), CBASE, BYTES);
  assign in_alm  = in_window(int'(addr_i), ABASE, BYTES);
  assign cnt_we  = wr_en_i && in_cnt && !lock_i;
  assign alm_we  = wr_en_i && in_alm && !lock_i;
  assign cnt_sel = SW'(int'(addr_i) - CBASE);
  assign alm_sel = SW'(int'(addr_i) - ABASE);
  assign step    = inc_i && !cnt_we;
  assign cnt_inc = step ? cnt_q + W'(1) : cnt_q;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign cnt_n[8*b +: 8] = (cnt_we && cnt_sel == SW'(b)) ? wdata_i : cnt_inc[8*b +: 8];
    assign alm_n[8*b +: 8] = (alm_we && alm_sel == SW'(b)) ? wdata_i : alm_q[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      alm_q  <= '0;
      hold_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      alm_q <= alm_n;
      hit_q <= step && (cnt_q + W'(1) == alm_q);
      if (snap_i) hold_q <= cnt_q;
    end
  end

  always_comb begin
    rd_o = 8'h00;
    for (int i = 0; i < BYTES; i++) begin
      if (int'(addr_i) == CBASE + i) rd_o = hold_q[8*i +: 8];
      if (int'(addr_i) == ABASE + i) rd_o = alm_q[8*i +: 8];
    end
  end

  assign hold_o = hold_q;
  assign hit_o  = hit_q;
endmodule

// File: rtl/tk_core.sv
module tk_core #(
  parameter int RTC_BYTES = 5,
  parameter int IVT_BYTES = 5,
  parameter int CYC_BYTES = 4,
  parameter int LONG_MS   = 123,
  parameter int SHORT_MS  = 4,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              ms_tick_i,
  input  logic              line_i,
  input  logic              snap_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  import tk_pkg::*;

  localparam int A_STAT = 0;
  localparam int A_CTRL = 1;
  localparam int A_RTC  = 2;
  localparam int A_IVT  = A_RTC + RTC_BYTES;
  localparam int A_CYC  = A_IVT + IVT_BYTES;
  localparam int A_RTCA = A_CYC + CYC_BYTES;
  localparam int A_IVTA = A_RTCA + RTC_BYTES;
  localparam int A_CYCA = A_IVTA + IVT_BYTES;

  logic [7:0]      ctrl_q;
  logic [NSRC-1:0] ien_q, flag_q, hit_vec, lock;
  logic            irq_q;
  logic [7:0]      rdata_q;
  logic            osc, ivt_run, level, fall;
  logic            wr_stat, wr_ctrl, rd_stat;
  logic [7:0]      status, rd_rtc, rd_ivt, rd_cyc, rd_d;
  logic [8*RTC_BYTES-1:0] rtc_hold;
  logic [8*IVT_BYTES-1:0] ivt_hold;
  logic [8*CYC_BYTES-1:0] cyc_hold;

  assign osc     = ctrl_q[CB_OSC];
  assign lock    = ctrl_q[NSRC-1:0];
  assign wr_stat = wr_en_i && int'(addr_i) == A_STAT;
  assign wr_ctrl = wr_en_i && int'(addr_i) == A_CTRL;
  assign rd_stat = rd_en_i && int'(addr_i) == A_STAT;
  assign status  = {2'b00, ien_q, flag_q};

  tk_line_qual #(.LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS)) u_qual (
    .clk(clk), .rst(rst), .line_i(line_i), .ms_tick_i(ms_tick_i),
    .long_sel_i(ctrl_q[CB_DSEL]), .level_o(level), .fall_o(fall)
  );

  assign ivt_run = ctrl_q[CB_AUTO] ? level : !ctrl_q[CB_STOP];

  tk_count_alarm #(.BYTES(RTC_BYTES), .ADDR_W(ADDR_W), .CBASE(A_RTC), .ABASE(A_RTCA)) u_rtc (
    .clk(clk), .rst(rst), .inc_i(tick_i && osc), .snap_i(snap_i),
    .lock_i(lock[SRC_RTC]), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .hold_o(rtc_hold), .rd_o(rd_rtc), .hit_o(hit_vec[SRC_RTC])
  );

  tk_count_alarm #(.BYTES(IVT_BYTES), .ADDR_W(ADDR_W), .CBASE(A_IVT), .ABASE(A_IVTA)) u_ivt (
    .clk(clk), .rst(rst), .inc_i(tick_i && osc && ivt_run), .snap_i(snap_i),
    .lock_i(lock[SRC_IVT]), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .hold_o(ivt_hold), .rd_o(rd_ivt), .hit_o(hit_vec[SRC_IVT])
  );

  tk_count_alarm #(.BYTES(CYC_BYTES), .ADDR_W(ADDR_W), .CBASE(A_CYC), .ABASE(A_CYCA)) u_cyc (
    .clk(clk), .rst(rst), .inc_i(fall && osc), .snap_i(snap_i),
    .lock_i(lock[SRC_CYC]), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .hold_o(cyc_hold), .rd_o(rd_cyc), .hit_o(hit_vec[SRC_CYC])
  );

  always_comb begin
    if (int'(addr_i) == A_STAT)      rd_d = status;
    else if (int'(addr_i) == A_CTRL) rd_d = ctrl_q;
    else                             rd_d = rd_rtc | rd_ivt | rd_cyc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= 8'h00;
      ien_q   <= '1;
      flag_q  <= '0;
      irq_q   <= 1'b0;
      rdata_q <= 8'h00;
    end else begin
      if (wr_ctrl) begin
        ctrl_q[7:NSRC]   <= wdata_i[7:NSRC];
        ctrl_q[NSRC-1:0] <= ctrl_q[NSRC-1:0] | wdata_i[NSRC-1:0];
      end
      if (wr_stat) ien_q <= wdata_i[2*NSRC-1:NSRC];
      flag_q <= (rd_stat ? '0 : flag_q) | hit_vec;
      irq_q  <= |(flag_q & ~ien_q);
      if (rd_en_i) rdata_q <= rd_d;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/tk_core_chk.sv
module tk_core_chk #(
  parameter int ADDR_W = 6,
  parameter int HW     = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              snap_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              irq_o,
  input logic [2:0]        flag_q,
  input logic [2:0]        ien_q,
  input logic [2:0]        hit_vec,
  input logic [2:0]        lock,
  input logic              osc,
  input logic [HW-1:0]     rtc_hold
);
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !snap_i |=> $stable(rtc_hold));

  assert_status_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == '0) |=> ((flag_q & ~$past(hit_vec)) == 3'b000));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (lock != 3'b000) |=> ((lock & $past(lock)) == $past(lock)));

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & ~ien_q) == 3'b000) |=> !irq_o);

  assert_no_hit_when_stopped_R3: assert property (@(posedge clk) disable iff (rst)
    !osc |=> (hit_vec == 3'b000));
endmodule

bind tk_core tk_core_chk #(.ADDR_W(ADDR_W), .HW(8*RTC_BYTES)) u_chk (
  .clk(clk), .rst(rst), .snap_i(snap_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
  .irq_o(irq_o), .flag_q(flag_q), .ien_q(ien_q), .hit_vec(hit_vec),
  .lock(lock), .osc(osc), .rtc_hold(rtc_hold)
);

// File: tb/test_tk_core.sv
module test_tk_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 0, ms_tick_i = 0, line_i = 0, snap_i = 0;
  logic       wr_en_i = 0, rd_en_i = 0;
  logic [5:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  tk_core i_tk_core (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ms_tick_i(ms_tick_i), .line_i(line_i),
    .snap_i(snap_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // monitor: compares read data one cycle after each read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en_i) begin
        @(negedge clk);
        chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); wr_en_i = 1; addr_i = 6'(a); wdata_i = d;
    @(negedge clk); wr_en_i = 0;
  endtask

  task automatic rd(int a, logic [7:0] e, string tag);
    @(negedge clk); rd_en_i = 1; addr_i = 6'(a);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en_i = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1;
      @(negedge clk); tick_i = 0;
    end
  endtask

  task automatic ms(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick_i = 1;
      @(negedge clk); ms_tick_i = 0;
    end
  endtask

  task automatic snap();
    @(negedge clk); snap_i = 1;
    @(negedge clk); snap_i = 0;
  endtask

  task automatic setline(logic v);
    @(negedge clk); line_i = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);
    rd(0, 8'h38, "R1 status reset");
    rd(1, 8'h00, "R1 control reset");
    snap();
    rd(2, 8'h00, "R1 rtc reset");
    // R3 oscillator off: ticks ignored
    ticks(5); snap();
    rd(2, 8'h00, "R3 rtc frozen with osc off");
    rd(7, 8'h00, "R3 interval frozen with osc off");
    // R2, R4 osc on, manual mode running
    wr(1, 8'h10);
    ticks(3); snap();
    rd(2, 8'h03, "R2 rtc count");
    rd(7, 8'h03, "R4 interval runs with stop bit 0");
    wr(1, 8'h50);
    ticks(2); snap();
    rd(2, 8'h05, "R2 rtc continues");
    rd(7, 8'h03, "R4 interval holds with stop bit 1");
    // R8 holding copy stays until the next snap
    ticks(2);
    rd(2, 8'h05, "R8 held copy unchanged");
    snap();
    rd(2, 8'h07, "R8 new snapshot");
    // R2 carry
    wr(2, 8'hFF);
    ticks(1); snap();
    rd(2, 8'h00, "R2 carry low byte");
    rd(3, 8'h01, "R2 carry next byte");
    // R7 status write only touches enables
    wr(0, 8'h37);
    rd(0, 8'h30, "R7 status write keeps flags");
    // R5, R6 rtc alarm at 0x102, rtc enable active (bit3 = 0)
    wr(16, 8'h02); wr(17, 8'h01);
    ticks(1); idle(4);
    chk("R6 irq low before match", {7'd0, irq_o}, 8'h00);
    ticks(1); idle(4);
    chk("R6 irq on rtc alarm", {7'd0, irq_o}, 8'h01);
    rd(0, 8'h31, "R5 rtc flag set");
    idle(2);
    chk("R7 irq cleared after status read", {7'd0, irq_o}, 8'h00);
    rd(0, 8'h30, "R7 flags cleared by read");
    // R9 write protect
    wr(1, 8'h51);
    wr(2, 8'h55); wr(16, 8'h77);
    snap();
    rd(2, 8'h02, "R9 protected counter write ignored");
    rd(16, 8'h02, "R9 protected alarm write ignored");
    wr(1, 8'h50);
    rd(1, 8'h51, "R9 protect bit sticky");
    // R10, R11 auto mode, short delay
    wr(1, 8'h31);
    setline(1); ms(3); ticks(2); snap();
    rd(7, 8'h03, "R10 not qualified before short delay");
    ms(1); ticks(2); snap();
    rd(7, 8'h05, "R11 interval runs on qualified high");
    setline(0); ms(3); setline(1); setline(0); ms(3);
    ticks(1); snap();
    rd(7, 8'h06, "R10 restart keeps level high");
    ms(1); idle(2); ticks(2); snap();
    rd(7, 8'h06, "R11 interval stops on qualified low");
    rd(12, 8'h01, "R12 cycle count after qualified fall");
    // R10 long delay
    wr(1, 8'hB1);
    setline(1); ms(122); ticks(1); snap();
    rd(7, 8'h06, "R10 long delay not reached");
    ms(1); ticks(1); snap();
    rd(7, 8'h07, "R10 long delay reached");
    // R5, R6, R12 masked cycle alarm
    wr(26, 8'h02);
    setline(0); ms(123); idle(4);
    chk("R6 masked flag keeps irq low", {7'd0, irq_o}, 8'h00);
    snap();
    rd(12, 8'h02, "R12 second qualified fall");
    rd(0, 8'h34, "R5 cycle flag set");
    // R13 unmapped
    rd(40, 8'h00, "R13 unmapped read");
    idle(3);
    finish_run();
  end
endmodule